// File: doc/BRIEF.md
# Median Clock Resynchronization Unit

This block keeps the local time counter of one node in a group of three or more loosely coupled nodes. The counter advances by one on every cycle in which the local tick input is high, so two nodes fed by slightly different tick rates slowly move apart. A resync request freezes a snapshot of the node's own count together with the counts it currently observes from each of its peers. It then replaces its own count with the median of that snapshot.

The median is found by odd-even transposition sorting over the snapshot, one compare-exchange pass per cycle. The counter keeps running while the sort is in progress. The ticks seen during that time are added back when the median is loaded, so the loaded value is the time the median clock would show at the load edge. A single-cycle done flag marks each completed resync. One faulty clock that shows the same wrong value to everyone is tolerated. A clock that shows different values to different observers can stop two healthy nodes from ever agreeing.

Top module: `median_resync_unit`

## Requirements
- R1: While reset is asserted, and after its release until the first tick, `localClock` is 0 and `resyncDone` is 0.
- R2: Outside a load cycle, `localClock` increases by exactly one (modulo 2^WIDTH, so all-ones wraps to 0) on each clock edge where `tickIn` is high, and holds its value when `tickIn` is low.
- R3: A request is accepted on an edge where `resyncReq` is high and no resync is in progress. The snapshot is the value `localClock` held just before that edge, plus each peer value present at that edge. Peer k (k = 0 .. NODES-2) occupies bits [k*WIDTH +: WIDTH] of `peerClocks`. Later changes of `peerClocks` do not affect the result.
- R4: The loaded value is element (NODES-1)/2 of the snapshot sorted in ascending unsigned order. To it is added the number of edges with `tickIn` high, counted from the accepting edge through the load edge, both included.
- R5: The load happens on the edge NODES+1 edges after the accepting edge. `resyncDone` is high for exactly the one cycle that follows that load edge.
- R6: A request raised while a resync is in progress is ignored. It changes neither the snapshot nor the result, and it produces no extra done pulse.
- R7: Equal values in the snapshot are handled deterministically. The result is the value at the median rank, whichever equal entries land there.
- R8: In a group of three with one clock that shows the same value to both healthy nodes: if that value is below both healthy clocks, both nodes take the lower healthy value. If it is above both, both take the higher one. If it lies between them, both take the faulty value.
- R9: In a group of three where the faulty clock appears just below the lower healthy node to that node and just above the higher healthy node to that node, each healthy node keeps its own value on every resync, and the two never converge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | Local oscillator tick; advances the counter by one |
| resyncReq | input | 1 | Request to resynchronize to the median |
| peerClocks | input | (NODES-1)*WIDTH | Observed peer clock values, peer k at bits [k*WIDTH +: WIDTH] |
| localClock | output | WIDTH | Local clock value |
| resyncDone | output | 1 | One-cycle pulse after each completed resync |

## Verification
Tick effects on `localClock` are visible in the same cycle as the edge that takes them. A resync accepted on edge E0 shows its loaded value and the done pulse after edge E0+NODES+1. For five nodes, the done pulse is therefore seen at the seventh falling edge after the falling edge that raised the request. A behavioural model keeps a queue of snapshot values and sorts it, counts ticks through the same window, and is compared with both outputs at every falling edge, away from the edges where they change. Directed sequences use two extra three-node instances to set up the consistent-fault cases and the two-faced case, and sample their outputs at the fifth falling edge after the request.

// File: rtl/medsync_pkg.sv
package medsync_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // take snapshot of own and peer clocks
    logic sortStep;  // apply one compare-exchange pass
    logic oddPass;   // pass pairs (1,2),(3,4).. when set, (0,1),(2,3).. when clear
    logic load;      // load median into the local counter
  } syncStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SORT = 2'd1,
    ST_LOAD = 2'd2
  } syncState_e;

endpackage

// File: rtl/medsync_ctrl.sv
module medsync_ctrl
  import medsync_pkg::*;
#(
  parameter int NODES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         resyncReq,
  output syncStrobes_t strb,
  output logic         doneQ
);

  localparam int PASS_W = (NODES > 2) ? $clog2(NODES) : 1;
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NODES - 1);

  syncState_e stateQ;
  logic [PASS_W-1:0] passQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      passQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= (stateQ == ST_LOAD);
      unique case (stateQ)
        ST_IDLE: begin
          if (resyncReq) begin
            stateQ <= ST_SORT;
            passQ  <= '0;
          end
        end
        ST_SORT: begin
          if (passQ == LAST_PASS) begin
            stateQ <= ST_LOAD;
          end else begin
            passQ <= passQ + 1'b1;
          end
        end
        ST_LOAD: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.capture  = (stateQ == ST_IDLE) && resyncReq;
    strb.sortStep = (stateQ == ST_SORT);
    strb.oddPass  = (stateQ == ST_SORT) && passQ[0];
    strb.load     = (stateQ == ST_LOAD);
  end

endmodule

// File: rtl/medsync_dpath.sv
module medsync_dpath
  import medsync_pkg::*;
#(
  parameter int NODES = 3,
  parameter int WIDTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tickIn,
  input  logic [(NODES-1)*WIDTH-1:0]   peerClocks,
  input  syncStrobes_t                 strb,
  output logic [WIDTH-1:0]             localClock
);

  localparam int MID = (NODES - 1) / 2;

  logic [WIDTH-1:0] clkQ;
  logic [WIDTH-1:0] elapsedQ;
  logic [WIDTH-1:0] tickExt;
  logic [WIDTH-1:0] smpQ   [NODES];
  logic [WIDTH-1:0] capVal [NODES];
  logic [WIDTH-1:0] nxtSmp [NODES];

  assign tickExt    = {{(WIDTH-1){1'b0}}, tickIn};
  assign localClock = clkQ;

  // snapshot sources: slot 0 is the own clock, slots 1.. are the peers
  assign capVal[0] = clkQ;
  for (genvar k = 1; k < NODES; k++) begin : g_peerTap
    assign capVal[k] = peerClocks[(k-1)*WIDTH +: WIDTH];
  end

  // one odd-even transposition pass over disjoint neighbour pairs
  always_comb begin
    for (int j = 0; j < NODES; j++) begin
      nxtSmp[j] = smpQ[j];
    end
    for (int j = 0; j < NODES - 1; j++) begin
      if ((((j % 2) == 1) == strb.oddPass) && (smpQ[j] > smpQ[j+1])) begin
        nxtSmp[j]   = smpQ[j+1];
        nxtSmp[j+1] = smpQ[j];
      end
    end
  end

  for (genvar k = 0; k < NODES; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        smpQ[k] <= '0;
      end else if (strb.capture) begin
        smpQ[k] <= capVal[k];
      end else if (strb.sortStep) begin
        smpQ[k] <= nxtSmp[k];
      end
    end
  end

  // ticks seen between snapshot and load, added back at load time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsedQ <= '0;
    end else if (strb.capture) begin
      elapsedQ <= tickExt;
    end else if (strb.sortStep) begin
      elapsedQ <= elapsedQ + tickExt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkQ <= '0;
    end else if (strb.load) begin
      clkQ <= smpQ[MID] + elapsedQ + tickExt;
    end else begin
      clkQ <= clkQ + tickExt;
    end
  end

endmodule

// File: rtl/median_resync_unit.sv
module median_resync_unit
  import medsync_pkg::*;
#(
  parameter int NODES = 3,   // group size, own clock included; at least 3
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tickIn,
  input  logic                       resyncReq,
  input  logic [(NODES-1)*WIDTH-1:0] peerClocks,
  output logic [WIDTH-1:0]           localClock,
  output logic                       resyncDone
);

  syncStrobes_t strb;

  medsync_ctrl #(.NODES(NODES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .resyncReq (resyncReq),
    .strb      (strb),
    .doneQ     (resyncDone)
  );

  medsync_dpath #(.NODES(NODES), .WIDTH(WIDTH)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .tickIn     (tickIn),
    .peerClocks (peerClocks),
    .strb       (strb),
    .localClock (localClock)
  );

endmodule

// File: rtl/medsync_chk.sv
module medsync_chk
  import medsync_pkg::*;
#(
  parameter int NODES = 3,
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickIn,
  input logic [WIDTH-1:0] localClock,
  input logic             resyncDone,
  input syncStrobes_t     strb
);

  int sinceCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCap <= 0;
    end else if (strb.capture) begin
      sinceCap <= 1;
    end else if (strb.load) begin
      sinceCap <= 0;
    end else if (sinceCap != 0) begin
      sinceCap <= sinceCap + 1;
    end
  end

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && tickIn) |=> (localClock == WIDTH'($past(localClock) + 1)));

  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !tickIn) |=> $stable(localClock));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resyncDone |=> !resyncDone);

  // R5
  load_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> resyncDone);

  // R5
  load_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (sinceCap == NODES + 1));

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (sinceCap == 0));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capture, strb.sortStep, strb.load}));

endmodule

bind median_resync_unit medsync_chk #(.NODES(NODES), .WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickIn     (tickIn),
  .localClock (localClock),
  .resyncDone (resyncDone),
  .strb       (strb)
);

// File: tb/median_resync_unit_tb.sv
`timescale 1ns/1ps
module median_resync_unit_tb;

  localparam int W  = 16;
  localparam int N5 = 5;
  localparam int N3 = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic tick, req;
  logic [(N5-1)*W-1:0] peers;
  logic [W-1:0] clkOut;
  logic done;

  logic reqT;
  logic tickT;
  logic [(N3-1)*W-1:0] peersA, peersB;
  logic [W-1:0] outA, outB;
  logic doneA, doneB;

  int nChk = 0;
  int nFail = 0;

  median_resync_unit #(.NODES(N5), .WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tick), .resyncReq(req),
    .peerClocks(peers), .localClock(clkOut), .resyncDone(done));

  median_resync_unit #(.NODES(N3), .WIDTH(W)) u_triA (
    .clk(clk), .rstN(rstN), .tickIn(tickT), .resyncReq(reqT),
    .peerClocks(peersA), .localClock(outA), .resyncDone(doneA));

  median_resync_unit #(.NODES(N3), .WIDTH(W)) u_triB (
    .clk(clk), .rstN(rstN), .tickIn(tickT), .resyncReq(reqT),
    .peerClocks(peersB), .localClock(outB), .resyncDone(doneB));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model for u_dut
  logic [W-1:0] mClk, mMed, mEl, mNxt;
  logic mDone;
  int mBusy, mCnt;
  int q[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mClk = '0; mDone = 1'b0; mBusy = 0; mCnt = 0; mEl = '0; mMed = '0;
    end else begin
      mDone = 1'b0;
      mNxt = mClk + W'(tick);
      if (mBusy != 0) begin
        mCnt++;
        mEl = mEl + W'(tick);
        if (mCnt == N5 + 1) begin
          mNxt = mMed + mEl;
          mBusy = 0;
          mDone = 1'b1;
        end
      end else if (req) begin
        q.delete();
        q.push_back(int'(mClk));
        for (int k = 0; k < N5 - 1; k++) q.push_back(int'(peers[k*W +: W]));
        q.sort();
        mMed = W'(q[(N5-1)/2]);
        mBusy = 1;
        mCnt = 0;
        mEl = W'(tick);
      end
      mClk = mNxt;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(mDone ? "R4 model load" : "R2 model count", clkOut, mClk);
      chk("R5 model done", W'(done), W'(mDone));
    end
  end

  task automatic dutRun(input logic [(N5-1)*W-1:0] pv);
    @(negedge clk); peers = pv; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (N5 + 1) @(negedge clk);
  endtask

  task automatic setDut(input logic [W-1:0] v);
    tick = 1'b0;
    dutRun({(N5-1){v}});
  endtask

  task automatic triRun(input logic [(N3-1)*W-1:0] pa, input logic [(N3-1)*W-1:0] pb);
    @(negedge clk); peersA = pa; peersB = pb; reqT = 1'b1;
    @(negedge clk); reqT = 1'b0;
    repeat (N3 + 1) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int doneCnt;
    int lat;
    rstN = 1'b0; tick = 1'b0; req = 1'b0; peers = '0;
    reqT = 1'b0; tickT = 1'b0; peersA = '0; peersB = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 clock in reset", clkOut, '0);
    chk("R1 done in reset", W'(done), '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 clock after release", clkOut, '0);

    // R2 free run and hold
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    chk("R2 ten ticks", clkOut, 16'd10);
    repeat (3) @(negedge clk);
    chk("R2 hold without tick", clkOut, 16'd10);

    // R4 basic median, own value set via equal peers
    setDut(16'd50);
    chk("R4 set own to 50", clkOut, 16'd50);

    // R3 and R6: snapshot at accepting edge, later request ignored
    @(negedge clk);
    peers = {16'd400, 16'd20, 16'd10, 16'd300};
    req = 1'b1;
    @(negedge clk);
    peers = {4{16'd900}};
    req = 1'b0;
    doneCnt = 0;
    for (int c = 0; c < 10; c++) begin
      req = (c == 2);
      @(negedge clk);
      if (done) doneCnt++;
    end
    req = 1'b0;
    chk("R3 snapshot at accept edge", clkOut, 16'd50);
    chk("R6 single done pulse", W'(doneCnt), 16'd1);

    // R5 latency: done at 7th falling edge after the request edge
    repeat (3) @(negedge clk);
    peers = {4{16'd77}};
    req = 1'b1;
    lat = 0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      req = 1'b0;
      if (done && lat == 0) lat = c;
    end
    chk("R5 latency in cycles", W'(lat), W'(N5 + 2));
    chk("R5 done pulse width", W'(done), '0);

    // R4 tick compensation: median 1000 plus 7 ticks
    setDut(16'd3);
    @(negedge clk);
    tick = 1'b1; peers = {4{16'd1000}}; req = 1'b1;
    @(negedge clk); req = 1'b0;
    repeat (N5 + 1) @(negedge clk);
    chk("R4 median plus ticks", clkOut, 16'd1007);
    @(negedge clk);
    chk("R2 runs on after load", clkOut, 16'd1008);
    tick = 1'b0;

    // R7 ties
    setDut(16'd50);
    dutRun({16'd1, 16'd50, 16'd1, 16'd50});
    chk("R7 ties own rank", clkOut, 16'd50);
    dutRun({16'd3, 16'd7, 16'd7, 16'd7});
    chk("R7 ties equal peers", clkOut, 16'd7);

    // R2 wrap
    setDut(16'hFFFE);
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    chk("R2 wraparound", clkOut, 16'd1);

    // random patterns against the model (includes busy requests, R6)
    for (int r = 0; r < 40; r++) begin
      @(negedge clk);
      peers = {$urandom(), $urandom()};
      req = 1'b1;
      tick = 1'($urandom());
      for (int c = 0; c < N5 + 2 + (r % 3); c++) begin
        @(negedge clk);
        req = (c == 2);
        tick = 1'($urandom());
      end
      req = 1'b0;
    end
    tick = 1'b0;

    // R8 consistent single fault, three-node groups, A=10 and B=20
    triRun({16'd10, 16'd10}, {16'd20, 16'd20});
    chk("R8 setup A", outA, 16'd10);
    chk("R8 setup B", outB, 16'd20);
    triRun({16'd5, 16'd20}, {16'd5, 16'd10});
    chk("R8 low fault A", outA, 16'd10);
    chk("R8 low fault B", outB, 16'd10);
    triRun({16'd10, 16'd10}, {16'd20, 16'd20});
    triRun({16'd30, 16'd20}, {16'd30, 16'd10});
    chk("R8 high fault A", outA, 16'd20);
    chk("R8 high fault B", outB, 16'd20);
    triRun({16'd10, 16'd10}, {16'd20, 16'd20});
    triRun({16'd15, 16'd20}, {16'd15, 16'd10});
    chk("R8 middle fault A", outA, 16'd15);
    chk("R8 middle fault B", outB, 16'd15);

    // R9 two-faced fault: A sees 8, B sees 22
    triRun({16'd10, 16'd10}, {16'd20, 16'd20});
    for (int r = 0; r < 3; r++) begin
      triRun({16'd8, outB}, {16'd22, outA});
      chk("R9 two-faced A keeps own", outA, 16'd10);
      chk("R9 two-faced B keeps own", outB, 16'd20);
    end

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule